// File: doc/BRIEF.md
# Fault Record Ring Writer

This block sits behind a memory-management unit and turns each reported page fault into a fixed 32-byte record in system or local memory. There are two circular buffers. One takes faults that can be replayed later and the other takes faults that cannot. A replayable-flag input picks the buffer for each fault. Software gives each buffer a base address, a record count (size) and a consumer index. The block owns the producer index and a sticky overflow flag for each buffer.

A record goes out as eight 32-bit word writes over a valid/ready memory-write port. Word 7 carries the valid bit and is always the last word written, so a reader polling that bit never sees a partly written record. A buffer is full when advancing the producer would make it equal the consumer. A fault that finds its buffer full is not written; it raises overflow instead. From then on every fault for that buffer is dropped until software pulses the clear. A level output tells the consumer that unread records exist in either buffer.

Top module: `fault_ring_writer`

## Requirements
- R1: A record for a buffer at producer index P is written as eight handshaked words. Word k (k = 0..7) goes to byte address base + 32*P + 4*k, in the order word 0 first and word 7 last. Address and data hold while ready is low.
- R2: `flt_replayable` = 1 sends the fault to buffer 1 and `flt_replayable` = 0 sends it to buffer 0. The other buffer's producer index does not change.
- R3: Word 0 holds the instance page bits [19:0] in bits 31:12 and the instance aperture in bits 9:8; all other bits of word 0 are zero. The aperture code is 0 for local video memory, 2 for coherent system memory and 3 for non-coherent system memory. Word 1 holds instance page bits [51:20].
- R4: Word 2 holds the fault page bits [19:0] in bits 31:12 and the fault aperture in bits 1:0, with zeros elsewhere. Word 3 holds fault page bits [51:20]. Words 4 and 5 hold stamp bits [31:0] and [63:32]. Word 6 holds the engine id in bits 8:0 and zeros above.
- R5: Word 7 holds these fields, with every other bit zero:
  - fault type in bits 4:0
  - replay flag in bit 7
  - client in bits 14:8
  - access kind in bits 19:16
  - cluster-client flag in bit 20
  - cluster id in bits 28:24
  - replay-enable in bit 30
  - valid = 1 in bit 31
- R6: The replay flag in word 7 is 1 only when `flt_replayable` = 1 and `flt_cancelled` = 0.
- R7: The producer index of a buffer steps by one, and wraps to 0 at its size, only after word 7 of a record has been accepted.
- R8: A fault arriving when (put+1) mod size equals get for its buffer is not written. Instead it sets that buffer's overflow flag.
- R9: While a buffer's overflow flag is set, every fault for it is dropped: there are no writes and the producer index does not change. The other buffer keeps working. A pulse on `ovf_clr[b]` clears the flag.
- R10: A pulse on `size_wr[b]` loads `size_val` into that buffer's size. A pulse on `size_dflt[b]` loads the default size DEF_SIZE (64).
- R11: `flt_ready` is high only when no record write is in progress. A fault is taken only in a cycle with `flt_valid` and `flt_ready` both high.
- R12: `nonempty` is high exactly when put differs from get for at least one buffer.
- R13: After reset, for both buffers:
  - producer indices are 0
  - overflow flags are 0
  - sizes are 64
  - `mw_valid` is 0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_valid | input | 1 | Fault descriptor present |
| flt_ready | output | 1 | Block idle, descriptor taken this cycle |
| flt_replayable | input | 1 | 1 = replayable buffer (1), 0 = other buffer (0) |
| flt_cancelled | input | 1 | Replayable fault marked cancelled |
| flt_inst_aper | input | 2 | Instance block aperture code |
| flt_inst_pg | input | 52 | Instance block 4 KiB page number |
| flt_addr_aper | input | 2 | Faulting address aperture |
| flt_addr_pg | input | 52 | Faulting address 4 KiB page number |
| flt_stamp | input | 64 | Timestamp |
| flt_engine | input | 9 | Engine id |
| flt_type | input | 5 | Fault type |
| flt_client | input | 7 | Client id |
| flt_access | input | 4 | Access kind |
| flt_gpc_client | input | 1 | Request came from a processing cluster |
| flt_cluster | input | 5 | Cluster id |
| flt_replay_en | input | 1 | Replay enabled in the instance |
| ring_base | input | 2x40 | Byte base address per buffer |
| ring_get | input | 2x16 | Consumer index per buffer |
| size_wr | input | 2 | Size load strobe per buffer |
| size_val | input | 16 | Size value for `size_wr` |
| size_dflt | input | 2 | Load default size per buffer |
| ovf_clr | input | 2 | Overflow clear strobe per buffer |
| put_idx | output | 2x16 | Producer index per buffer |
| ring_size | output | 2x16 | Current size per buffer |
| ovf | output | 2 | Overflow flag per buffer |
| nonempty | output | 1 | Unread records exist |
| mw_valid | output | 1 | Memory word write valid |
| mw_ready | input | 1 | Memory word write accepted |
| mw_addr | output | 40 | Byte address of the word |
| mw_data | output | 32 | Word data |

## Verification
The hardest state to reach is a buffer that is both full and latched in overflow, while the other buffer still has room. The bench shrinks one buffer to four records, moves its consumer index, and writes until the producer wraps and meets the full condition. It then sends further faults and checks that:
- the write log does not grow
- the producer index is frozen
- a replayable fault still lands in the other buffer

It also empties the small buffer while overflow is still set and checks that faults stay dropped until the clear pulse.

// File: rtl/fault_ring_pkg.sv
package fault_ring_pkg;

    localparam int NBUF      = 2;
    localparam int PG_W      = 52;
    localparam int WORDS     = 8;
    localparam int WIDX_W    = $clog2(WORDS);
    localparam int REC_SHIFT = $clog2(WORDS * 4);

    localparam logic [1:0] APER_LOCAL  = 2'd0;
    localparam logic [1:0] APER_SYS_CO = 2'd2;
    localparam logic [1:0] APER_SYS_NC = 2'd3;

    typedef struct packed {
        logic [1:0]      inst_aper;
        logic [PG_W-1:0] inst_pg;
        logic [1:0]      addr_aper;
        logic [PG_W-1:0] addr_pg;
        logic [63:0]     stamp;
        logic [8:0]      engine;
        logic [4:0]      ftype;
        logic            rflag;
        logic [6:0]      client;
        logic [3:0]      access;
        logic            gpc_client;
        logic [4:0]      cluster;
        logic            replay_en;
    } fault_desc_t;

    typedef logic [WORDS-1:0][31:0] record_t;

    function automatic logic replay_flag(input logic replayable, input logic cancelled);
        return replayable & ~cancelled;
    endfunction

endpackage

// File: rtl/fault_rec_pack.sv
module fault_rec_pack
    import fault_ring_pkg::*;
(
    input  fault_desc_t desc,
    output record_t     rec
);
    always_comb begin
        rec = '0;
        rec[0][31:12] = desc.inst_pg[19:0];
        rec[0][9:8]   = desc.inst_aper;
        rec[1]        = desc.inst_pg[PG_W-1:20];
        rec[2][31:12] = desc.addr_pg[19:0];
        rec[2][1:0]   = desc.addr_aper;
        rec[3]        = desc.addr_pg[PG_W-1:20];
        rec[4]        = desc.stamp[31:0];
        rec[5]        = desc.stamp[63:32];
        rec[6][8:0]   = desc.engine;
        rec[7][4:0]   = desc.ftype;
        rec[7][7]     = desc.rflag;
        rec[7][14:8]  = desc.client;
        rec[7][19:16] = desc.access;
        rec[7][20]    = desc.gpc_client;
        rec[7][28:24] = desc.cluster;
        rec[7][30]    = desc.replay_en;
        rec[7][31]    = 1'b1;
    end
endmodule

// File: rtl/fault_ring_state.sv
module fault_ring_state #(
    parameter int IDX_W    = 16,
    parameter int DEF_SIZE = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             size_wr,
    input  logic [IDX_W-1:0] size_val,
    input  logic             size_dflt,
    input  logic [IDX_W-1:0] get_idx,
    input  logic             ovf_clr,
    input  logic             ovf_set,
    input  logic             advance,
    output logic [IDX_W-1:0] put,
    output logic [IDX_W-1:0] size,
    output logic             ovf,
    output logic             full,
    output logic             nonempty
);
    localparam logic [IDX_W-1:0] DEF = IDX_W'(DEF_SIZE);
    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

    logic [IDX_W-1:0] put_inc;
    logic [IDX_W-1:0] put_nxt;

    always_comb begin
        put_inc  = put + ONE;
        put_nxt  = (put_inc == size) ? '0 : put_inc;
        full     = (put_nxt == get_idx);
        nonempty = (put != get_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            put  <= '0;
            size <= DEF;
            ovf  <= 1'b0;
        end else begin
            if (advance)        put <= put_nxt;
            if (size_dflt)      size <= DEF;
            else if (size_wr)   size <= size_val;
            if (ovf_set)        ovf <= 1'b1;
            else if (ovf_clr)   ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/fault_rec_sender.sv
module fault_rec_sender
    import fault_ring_pkg::*;
#(
    parameter int AW = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  record_t           rec_in,
    input  logic [AW-1:0]     row_addr,
    input  logic              mw_ready,
    output logic              mw_valid,
    output logic [AW-1:0]     mw_addr,
    output logic [31:0]       mw_data,
    output logic              busy,
    output logic              done,
    output logic [WIDX_W-1:0] word_idx
);
    localparam logic [WIDX_W-1:0] LAST = WIDX_W'(WORDS - 1);

    record_t       rec_q;
    logic [AW-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            word_idx <= '0;
            rec_q    <= '0;
            row_q    <= '0;
        end else if (!busy) begin
            if (start) begin
                busy     <= 1'b1;
                word_idx <= '0;
                rec_q    <= rec_in;
                row_q    <= row_addr;
            end
        end else if (mw_ready) begin
            if (word_idx == LAST) begin
                busy     <= 1'b0;
                word_idx <= '0;
            end else begin
                word_idx <= word_idx + 1'b1;
            end
        end
    end

    always_comb begin
        mw_valid = busy;
        mw_addr  = row_q + AW'({word_idx, 2'b00});
        mw_data  = rec_q[word_idx];
        done     = busy && mw_ready && (word_idx == LAST);
    end
endmodule

// File: rtl/fault_ring_writer.sv
module fault_ring_writer
    import fault_ring_pkg::*;
#(
    parameter int AW       = 40,
    parameter int IDX_W    = 16,
    parameter int DEF_SIZE = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flt_valid,
    output logic                       flt_ready,
    input  logic                       flt_replayable,
    input  logic                       flt_cancelled,
    input  logic [1:0]                 flt_inst_aper,
    input  logic [51:0]                flt_inst_pg,
    input  logic [1:0]                 flt_addr_aper,
    input  logic [51:0]                flt_addr_pg,
    input  logic [63:0]                flt_stamp,
    input  logic [8:0]                 flt_engine,
    input  logic [4:0]                 flt_type,
    input  logic [6:0]                 flt_client,
    input  logic [3:0]                 flt_access,
    input  logic                       flt_gpc_client,
    input  logic [4:0]                 flt_cluster,
    input  logic                       flt_replay_en,
    input  logic [1:0][AW-1:0]         ring_base,
    input  logic [1:0][IDX_W-1:0]      ring_get,
    input  logic [1:0]                 size_wr,
    input  logic [IDX_W-1:0]           size_val,
    input  logic [1:0]                 size_dflt,
    input  logic [1:0]                 ovf_clr,
    output logic [1:0][IDX_W-1:0]      put_idx,
    output logic [1:0][IDX_W-1:0]      ring_size,
    output logic [1:0]                 ovf,
    output logic                       nonempty,
    output logic                       mw_valid,
    input  logic                       mw_ready,
    output logic [AW-1:0]              mw_addr,
    output logic [31:0]                mw_data
);
    fault_desc_t       desc;
    record_t           rec;
    logic              sel, sel_q;
    logic              busy, done, accept, start;
    logic [WIDX_W-1:0] word_idx;
    logic [AW-1:0]     row_addr;
    logic [NBUF-1:0]   full_v, ne_v, ovf_set_v, adv_v;

    always_comb begin
        desc.inst_aper  = flt_inst_aper;
        desc.inst_pg    = flt_inst_pg;
        desc.addr_aper  = flt_addr_aper;
        desc.addr_pg    = flt_addr_pg;
        desc.stamp      = flt_stamp;
        desc.engine     = flt_engine;
        desc.ftype      = flt_type;
        desc.rflag      = replay_flag(flt_replayable, flt_cancelled);
        desc.client     = flt_client;
        desc.access     = flt_access;
        desc.gpc_client = flt_gpc_client;
        desc.cluster    = flt_cluster;
        desc.replay_en  = flt_replay_en;
    end

    fault_rec_pack u_pack (.desc(desc), .rec(rec));

    always_comb begin
        sel       = flt_replayable;
        flt_ready = !busy;
        accept    = flt_valid && !busy;
        start     = accept && !ovf[sel] && !full_v[sel];
        row_addr  = ring_base[sel] + (AW'(put_idx[sel]) << REC_SHIFT);
        nonempty  = |ne_v;
    end

    always_ff @(posedge clk) begin
        if (rst)        sel_q <= 1'b0;
        else if (start) sel_q <= sel;
    end

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        assign ovf_set_v[b] = accept && (sel == 1'(b)) && !ovf[b] && full_v[b];
        assign adv_v[b]     = done && (sel_q == 1'(b));

        fault_ring_state #(.IDX_W(IDX_W), .DEF_SIZE(DEF_SIZE)) u_state (
            .clk      (clk),
            .rst      (rst),
            .size_wr  (size_wr[b]),
            .size_val (size_val),
            .size_dflt(size_dflt[b]),
            .get_idx  (ring_get[b]),
            .ovf_clr  (ovf_clr[b]),
            .ovf_set  (ovf_set_v[b]),
            .advance  (adv_v[b]),
            .put      (put_idx[b]),
            .size     (ring_size[b]),
            .ovf      (ovf[b]),
            .full     (full_v[b]),
            .nonempty (ne_v[b])
        );
    end

    fault_rec_sender #(.AW(AW)) u_send (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .rec_in  (rec),
        .row_addr(row_addr),
        .mw_ready(mw_ready),
        .mw_valid(mw_valid),
        .mw_addr (mw_addr),
        .mw_data (mw_data),
        .busy    (busy),
        .done    (done),
        .word_idx(word_idx)
    );
endmodule

// File: rtl/fault_ring_writer_chk.sv
module fault_ring_writer_chk #(
    parameter int AW    = 40,
    parameter int IDX_W = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  flt_valid,
    input logic                  flt_ready,
    input logic                  mw_valid,
    input logic                  mw_ready,
    input logic [AW-1:0]         mw_addr,
    input logic [31:0]           mw_data,
    input logic [2:0]            word_idx,
    input logic [1:0][IDX_W-1:0] put_idx,
    input logic [1:0]            ovf,
    input logic [1:0]            ovf_clr
);
    a_r1_hold_word: assert property (@(posedge clk) disable iff (rst)
        mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data));

    a_r1_word_order: assert property (@(posedge clk) disable iff (rst)
        mw_valid && mw_ready && (word_idx != 3'd7) |=> mw_valid && (word_idx == $past(word_idx) + 3'd1));

    a_r5_valid_last: assert property (@(posedge clk) disable iff (rst)
        mw_valid && (word_idx == 3'd7) |-> mw_data[31]);

    a_r11_idle_only: assert property (@(posedge clk) disable iff (rst)
        flt_ready |-> !mw_valid);

    for (genvar b = 0; b < 2; b++) begin : g_b
        a_r7_put_after_last: assert property (@(posedge clk) disable iff (rst)
            !$stable(put_idx[b]) |-> $past(mw_valid && mw_ready && (word_idx == 3'd7)));

        a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
            ovf[b] && !ovf_clr[b] |=> ovf[b]);

        a_r8_ovf_on_accept: assert property (@(posedge clk) disable iff (rst)
            $rose(ovf[b]) |-> $past(flt_valid && flt_ready));
    end
endmodule

bind fault_ring_writer fault_ring_writer_chk #(.AW(AW), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .flt_valid(flt_valid),
    .flt_ready(flt_ready),
    .mw_valid (mw_valid),
    .mw_ready (mw_ready),
    .mw_addr  (mw_addr),
    .mw_data  (mw_data),
    .word_idx (word_idx),
    .put_idx  (put_idx),
    .ovf      (ovf),
    .ovf_clr  (ovf_clr)
);

// File: tb/fault_ring_writer_tb.sv
`timescale 1ns/1ps
module fault_ring_writer_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic flt_valid = 0, flt_ready, flt_replayable = 0, flt_cancelled = 0;
    logic [1:0] flt_inst_aper = 0, flt_addr_aper = 0;
    logic [51:0] flt_inst_pg = 0, flt_addr_pg = 0;
    logic [63:0] flt_stamp = 0;
    logic [8:0] flt_engine = 0;
    logic [4:0] flt_type = 0, flt_cluster = 0;
    logic [6:0] flt_client = 0;
    logic [3:0] flt_access = 0;
    logic flt_gpc_client = 0, flt_replay_en = 0;
    logic [1:0][39:0] ring_base;
    logic [1:0][15:0] ring_get;
    logic [1:0] size_wr = 0, size_dflt = 0, ovf_clr = 0, ovf;
    logic [15:0] size_val = 0;
    logic [1:0][15:0] put_idx, ring_size;
    logic nonempty, mw_valid, mw_ready;
    logic [39:0] mw_addr;
    logic [31:0] mw_data;

    fault_ring_writer u_dut (.*);

    typedef struct packed {
        logic rep; logic canc; logic [1:0] iap; logic [51:0] ipg;
        logic [1:0] aap; logic [51:0] apg; logic [63:0] ts; logic [8:0] eng;
        logic [4:0] ft; logic [6:0] cl; logic [3:0] ac; logic gc; logic [4:0] cid; logic ren;
        logic [31:0] w0; logic [31:0] w2; logic [31:0] w6; logic [31:0] w7;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{rep:1'b0, canc:1'b0, iap:2'd0, ipg:{32'hA000_0001, 20'h12345}, aap:2'd1,
          apg:{32'h0000_00BB, 20'hCAFE0}, ts:64'h0000_0011_2233_4455, eng:9'h1FF,
          ft:5'h1F, cl:7'h7F, ac:4'hF, gc:1'b1, cid:5'h1F, ren:1'b1,
          w0:32'h1234_5000, w2:32'hCAFE_0001, w6:32'h0000_01FF, w7:32'hDF1F_7F1F},
        '{rep:1'b1, canc:1'b0, iap:2'd2, ipg:{32'h0, 20'h00001}, aap:2'd2,
          apg:{32'hFFFF_FFFF, 20'hFFFFF}, ts:64'hDEAD_BEEF_0000_0001, eng:9'h100,
          ft:5'h05, cl:7'h01, ac:4'h2, gc:1'b0, cid:5'h03, ren:1'b0,
          w0:32'h0000_1200, w2:32'hFFFF_F002, w6:32'h0000_0100, w7:32'h8302_0185},
        '{rep:1'b1, canc:1'b1, iap:2'd3, ipg:{32'h1234_5678, 20'hABCDE}, aap:2'd3,
          apg:{32'h1, 20'h0}, ts:64'h0, eng:9'h0,
          ft:5'h10, cl:7'h40, ac:4'h8, gc:1'b1, cid:5'h10, ren:1'b1,
          w0:32'hABCD_E300, w2:32'h0000_0003, w6:32'h0, w7:32'hD018_4010},
        '{rep:1'b0, canc:1'b1, iap:2'd0, ipg:52'h0, aap:2'd0, apg:52'h0, ts:64'h0, eng:9'h0,
          ft:5'h01, cl:7'h0, ac:4'h0, gc:1'b0, cid:5'h0, ren:1'b0,
          w0:32'h0, w2:32'h0, w6:32'h0, w7:32'h8000_0001},
        '{rep:1'b1, canc:1'b0, iap:2'd0, ipg:52'h0, aap:2'd0, apg:52'h0, ts:64'h0, eng:9'h0,
          ft:5'h01, cl:7'h0, ac:4'h0, gc:1'b0, cid:5'h0, ren:1'b0,
          w0:32'h0, w2:32'h0, w6:32'h0, w7:32'h8000_0081}
    };

    int checks = 0, errors = 0, cap_n = 0, cyc = 0, rcnt = 0;
    bit fin = 0;
    logic [39:0] cap_addr [0:255];
    logic [31:0] cap_data [0:255];
    int exp_put [2];

    // memory side: pick ready for the coming edge, then log the handshake
    always @(negedge clk) begin
        rcnt++;
        mw_ready = (rcnt % 3) != 1;
        if (mw_valid && mw_ready && cap_n < 256) begin
            cap_addr[cap_n] = mw_addr;
            cap_data[cap_n] = mw_data;
            cap_n++;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !fin) begin
            fin = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            summary();
            $finish;
        end
    end

    task automatic send(input vec_t v);
        while (!flt_ready) @(negedge clk);
        flt_replayable = v.rep; flt_cancelled = v.canc;
        flt_inst_aper = v.iap; flt_inst_pg = v.ipg;
        flt_addr_aper = v.aap; flt_addr_pg = v.apg;
        flt_stamp = v.ts; flt_engine = v.eng; flt_type = v.ft; flt_client = v.cl;
        flt_access = v.ac; flt_gpc_client = v.gc; flt_cluster = v.cid; flt_replay_en = v.ren;
        flt_valid = 1'b1;
        @(negedge clk);
        flt_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!flt_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_rec(input int start, input int b, input int idx, input vec_t v);
        logic [7:0][31:0] e;
        e[0] = v.w0; e[1] = v.ipg[51:20]; e[2] = v.w2; e[3] = v.apg[51:20];
        e[4] = v.ts[31:0]; e[5] = v.ts[63:32]; e[6] = v.w6; e[7] = v.w7;
        chk("R1 write count", 64'(cap_n), 64'(start + 8));
        for (int k = 0; k < 8; k++) begin
            chk("R1 R2 word address", 64'(cap_addr[start+k]),
                64'(ring_base[b] + 40'(idx * 32 + k * 4)));
            if (k < 2)      chk("R3 word 0/1", 64'(cap_data[start+k]), 64'(e[k]));
            else if (k < 7) chk("R4 word 2..6", 64'(cap_data[start+k]), 64'(e[k]));
            else            chk("R5 word 7 last with valid", 64'(cap_data[start+k]), 64'(e[k]));
        end
    endtask

    task automatic write_ok(input vec_t v);
        int s, b;
        s = cap_n; b = int'(v.rep);
        send(v);
        wait_idle();
        check_rec(s, b, exp_put[b], v);
        exp_put[b] = (exp_put[b] + 1) % int'(ring_size[b]);
        chk("R7 put step", 64'(put_idx[b]), 64'(exp_put[b]));
        chk("R2 other buffer put", 64'(put_idx[1-b]), 64'(exp_put[1-b]));
    endtask

    task automatic drop(input vec_t v, input string tag);
        int s, b;
        s = cap_n; b = int'(v.rep);
        send(v);
        wait_idle();
        chk({tag, " no writes"}, 64'(cap_n), 64'(s));
        chk({tag, " put frozen"}, 64'(put_idx[b]), 64'(exp_put[b]));
        chk({tag, " ovf set"}, 64'(ovf[b]), 64'd1);
    endtask

    initial begin
        ring_base[0] = 40'h00_1000_0000;
        ring_base[1] = 40'h00_2000_0400;
        ring_get = '0;
        exp_put[0] = 0; exp_put[1] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R13 reset state
        chk("R13 put0", 64'(put_idx[0]), 0);
        chk("R13 put1", 64'(put_idx[1]), 0);
        chk("R13 ovf", 64'(ovf), 0);
        chk("R13 size0", 64'(ring_size[0]), 64);
        chk("R13 size1", 64'(ring_size[1]), 64);
        chk("R13 mw_valid", 64'(mw_valid), 0);
        chk("R12 nonempty at reset", 64'(nonempty), 0);
        chk("R11 ready at reset", 64'(flt_ready), 1);

        // table walk: field packing and buffer choice
        for (int i = 0; i < 5; i++) begin
            int s, b;
            s = cap_n; b = int'(VECS[i].rep);
            send(VECS[i]);
            chk("R11 busy blocks ready", 64'(flt_ready), 0);
            wait_idle();
            check_rec(s, b, exp_put[b], VECS[i]);
            exp_put[b]++;
            chk("R7 put step", 64'(put_idx[b]), 64'(exp_put[b]));
            chk("R2 other buffer put", 64'(put_idx[1-b]), 64'(exp_put[1-b]));
            chk("R6 replay flag", 64'(cap_data[s+7][7]), 64'(VECS[i].rep & ~VECS[i].canc));
        end
        chk("R12 nonempty with unread", 64'(nonempty), 1);

        // R10 size load, then wrap and full on buffer 0 (put0 = 2)
        size_val = 16'd4; size_wr = 2'b01;
        @(negedge clk);
        size_wr = 2'b00;
        chk("R10 size write", 64'(ring_size[0]), 4);
        ring_get[0] = 16'd2;
        write_ok(VECS[3]);                     // index 2 -> put 3
        write_ok(VECS[3]);                     // index 3 -> put 0 (R7 wrap)
        chk("R7 wrap to zero", 64'(put_idx[0]), 0);
        write_ok(VECS[3]);                     // index 0 -> put 1, now full
        chk("R8 no ovf before full hit", 64'(ovf[0]), 0);
        drop(VECS[3], "R8 full");
        drop(VECS[3], "R9 while ovf");
        write_ok(VECS[4]);                     // other buffer keeps working
        chk("R9 other buffer ovf clear", 64'(ovf[1]), 0);
        ring_get[0] = 16'd1;                   // ring empty, ovf still set
        drop(VECS[3], "R9 empty but ovf");
        ovf_clr = 2'b01;
        @(negedge clk);
        ovf_clr = 2'b00;
        chk("R9 clear pulse", 64'(ovf[0]), 0);
        write_ok(VECS[3]);                     // index 1 -> put 2
        chk("R9 write resumes", 64'(put_idx[0]), 2);

        size_dflt = 2'b01;
        @(negedge clk);
        size_dflt = 2'b00;
        chk("R10 default size", 64'(ring_size[0]), 64);

        ring_get[0] = put_idx[0]; ring_get[1] = put_idx[1];
        @(negedge clk);
        chk("R12 all consumed", 64'(nonempty), 0);
        ring_get[1] = put_idx[1] - 16'd1;
        @(negedge clk);
        chk("R12 one unread", 64'(nonempty), 1);

        fin = 1;
        summary();
        $finish;
    end
endmodule